// File: doc/BRIEF.md
# Prescaled PWM Timer with Edge and Wrap Interrupts

This block is a single-channel pulse-width modulation timer. A 24-bit up-counter advances on ticks from a prescaler. The prescaler divides the block clock by 1, 16, 256 or 2048. In each period the counter runs from 0 up to a programmed period value and then clears to 0.

The output is driven low at the start of each period for a programmed number of counts, and high for the rest of the period. An invert bit swaps the two levels. The low width is copied into a shadow register, so a change made while the timer runs only takes effect from the next period.

Three latched interrupt flags record output rising edges, output falling edges and counter wraps. Each flag has its own enable bit and is cleared by writing 1 to it. Software uses a one-cycle write/read port: it writes the period and low width with the timer stopped, then sets the run bit.

Top module: `pwm_timer`

## Requirements
- R1: After reset, the output and the interrupt line are low, and every register reads 0.
- R2: The prescaler code in control bits [3:2] selects the tick rate: code 0 gives every clock, 1 gives every 16th, 2 every 256th and 3 every 2048th. The counter counts 0..P, where P is the period register (address 1). One output period therefore lasts div*(P+1) clocks.
- R3: With polarity normal, the output is low while the count is below the shadowed low width (address 2) and high otherwise. A width of 0 never drives it low. A width above P keeps it low for the whole period.
- R4: Control bit 1 inverts the output. The low and high phases swap, and the number of low clocks becomes the number of high clocks.
- R5: While the run bit (control bit 0) is 0, the counter and prescaler are held at 0, and the output sits at the level of control bit 1.
- R6: A write to the period register while the run bit is 1 is ignored: the register reads back its old value, and the output period is unchanged.
- R7: A low width written while running takes effect at the next counter wrap and never part way through a period. The shadow follows the register while the timer is stopped.
- R8: The flag register (address 4) holds bit 0 for a rising output edge, bit 1 for a falling output edge and bit 2 for a counter wrap. A flag is set only when the enable bit in the same position of address 3 is 1.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an event occurs in the same cycle, the set wins.
- R10: The interrupt line is the OR of the flags that are set and enabled. Clearing an enable bit lowers the line without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 control, 1 period, 2 low width, 3 interrupt enable, 4 interrupt flags) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Registered PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is applied before any access, and that `wr_en`, `addr` and `wdata` are known in every cycle. The assertion that the count stays at or below the period relies on the period being frozen while running. It also relies on the count starting from 0 whenever the run bit rises. The bench keeps to these assumptions: it holds reset for several cycles, drives every input from time zero, and changes inputs only at falling clock edges. It also changes the period, width and prescaler only after clearing the run bit, except in the two tests that deliberately write the period or the width mid-run.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

    localparam int CNT_W  = 24;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int PSC_W  = 11;
    localparam int N_IRQ  = 3;

    localparam int IRQ_RISE = 0;
    localparam int IRQ_FALL = 1;
    localparam int IRQ_WRAP = 2;

    typedef enum logic [1:0] {
        PSC_DIV1    = 2'd0,
        PSC_DIV16   = 2'd1,
        PSC_DIV256  = 2'd2,
        PSC_DIV2048 = 2'd3
    } psc_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_PERIOD = 3'd1,
        A_LOWW   = 3'd2,
        A_IEN    = 3'd3,
        A_IFLAG  = 3'd4
    } addr_e;

    typedef struct packed {
        psc_e psc;
        logic inv;
        logic run;
    } ctrl_t;

    function automatic int psc_shift(psc_e s);
        case (s)
            PSC_DIV1:   return 0;
            PSC_DIV16:  return 4;
            PSC_DIV256: return 8;
            default:    return 11;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
`timescale 1ns/1ps
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NI = N_IRQ
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NI-1:0] flags,
    output logic [DW-1:0] rdata,
    output ctrl_t         ctrl,
    output logic [CW-1:0] period,
    output logic [CW-1:0] low_w,
    output logic [NI-1:0] irq_en,
    output logic [NI-1:0] clr_mask
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DW-1:CW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            period <= '0;
            low_w  <= '0;
            irq_en <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    ctrl.run <= wdata[0];
                    ctrl.inv <= wdata[1];
                    ctrl.psc <= psc_e'(wdata[3:2]);
                end
                A_PERIOD: if (!ctrl.run) period <= wdata[CW-1:0];
                A_LOWW:   low_w  <= wdata[CW-1:0];
                A_IEN:    irq_en <= wdata[NI-1:0];
                default: ;
            endcase
        end
    end

    assign clr_mask = (wr_en && addr == A_IFLAG) ? wdata[NI-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[3:0]    = {ctrl.psc, ctrl.inv, ctrl.run};
            A_PERIOD: rdata[CW-1:0] = period;
            A_LOWW:   rdata[CW-1:0] = low_w;
            A_IEN:    rdata[NI-1:0] = irq_en;
            A_IFLAG:  rdata[NI-1:0] = flags;
            default:  rdata = '0;
        endcase
    end

    // R6: period frozen while the timer runs
    p_period_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |=> $stable(period));

endmodule

// File: rtl/pwmt_prescale.sv
`timescale 1ns/1ps
module pwmt_prescale
    import pwmt_pkg::*;
#(
    parameter int PW = PSC_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  psc_e sel,
    output logic tick
);

    logic [PW-1:0] lim;
    logic [PW-1:0] pre_q;

    assign lim  = PW'((1 << psc_shift(sel)) - 1);
    assign tick = run && (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/pwmt_core.sv
`timescale 1ns/1ps
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          inv,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] low_w,
    output logic          pwm_q,
    output logic          wrap
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] shadow_q;
    logic          at_end;
    logic          level;

    assign at_end = (cnt_q == period);
    assign wrap   = run && tick && at_end;
    assign level  = run ? ((cnt_q >= shadow_q) ^ inv) : inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            shadow_q <= '0;
            pwm_q    <= 1'b0;
        end else begin
            if (!run) begin
                cnt_q    <= '0;
                shadow_q <= low_w;
            end else if (tick) begin
                if (at_end) begin
                    cnt_q    <= '0;
                    shadow_q <= low_w;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            pwm_q <= level;
        end
    end

    // R2: count never passes the period while running
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= period));

    // R7: shadow width only moves at a wrap or while stopped
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(shadow_q));

    // R5: stopped output sits at the polarity level
    p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pwm_q == $past(inv)));

endmodule

// File: rtl/pwmt_irq.sv
`timescale 1ns/1ps
module pwmt_irq
    import pwmt_pkg::*;
#(
    parameter int NI = N_IRQ
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwm,
    input  logic          wrap,
    input  logic [NI-1:0] en,
    input  logic [NI-1:0] clr,
    output logic [NI-1:0] flags,
    output logic          irq
);

    logic          pwm_prev;
    logic [NI-1:0] ev;

    always_ff @(posedge clk) begin
        if (rst) pwm_prev <= 1'b0;
        else     pwm_prev <= pwm;
    end

    always_comb begin
        ev           = '0;
        ev[IRQ_RISE] = pwm && !pwm_prev;
        ev[IRQ_FALL] = !pwm && pwm_prev;
        ev[IRQ_WRAP] = wrap;
    end

    for (genvar gi = 0; gi < NI; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[gi] <= 1'b0;
            else if (ev[gi] && en[gi])
                flags[gi] <= 1'b1;
            else if (clr[gi])
                flags[gi] <= 1'b0;
        end

        // R9: a write of one clears the flag absent a new event
        p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
            (clr[gi] && !ev[gi]) |=> !flags[gi]);

        // R8: a disabled source never raises its flag
        p_gate_r8: assert property (@(posedge clk) disable iff (rst)
            (!en[gi] && !flags[gi]) |=> !flags[gi]);
    end

    assign irq = |(flags & en);

endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pwm_out,
    output logic          irq
);

    ctrl_t            ctrl;
    logic [CW-1:0]    period;
    logic [CW-1:0]    low_w;
    logic [N_IRQ-1:0] irq_en;
    logic [N_IRQ-1:0] clr_mask;
    logic [N_IRQ-1:0] flags;
    logic             tick;
    logic             wrap;

    pwmt_regs #(.CW(CW), .DW(DW), .AW(AW), .NI(N_IRQ)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flags(flags), .rdata(rdata), .ctrl(ctrl), .period(period),
        .low_w(low_w), .irq_en(irq_en), .clr_mask(clr_mask)
    );

    pwmt_prescale #(.PW(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .run(ctrl.run), .sel(ctrl.psc), .tick(tick)
    );

    pwmt_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .run(ctrl.run), .inv(ctrl.inv), .tick(tick),
        .period(period), .low_w(low_w), .pwm_q(pwm_out), .wrap(wrap)
    );

    pwmt_irq #(.NI(N_IRQ)) u_irq (
        .clk(clk), .rst(rst), .pwm(pwm_out), .wrap(wrap), .en(irq_en),
        .clr(clr_mask), .flags(flags), .irq(irq)
    );

endmodule

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  psc;
        logic [23:0] per;
        logic [23:0] low;
        logic        inv;
        logic [31:0] exp_low;
        logic [31:0] exp_rise;
    } vec_t;

    // exp_low: low clocks in one period; exp_rise: rising edges in two periods
    localparam vec_t VECS [9] = '{
        '{2'd0, 24'd9, 24'd3,  1'b0, 32'd3,    32'd2},
        '{2'd0, 24'd9, 24'd3,  1'b1, 32'd7,    32'd2},
        '{2'd0, 24'd9, 24'd0,  1'b0, 32'd0,    32'd0},
        '{2'd0, 24'd9, 24'd12, 1'b0, 32'd10,   32'd0},
        '{2'd0, 24'd9, 24'd9,  1'b0, 32'd9,    32'd2},
        '{2'd1, 24'd4, 24'd2,  1'b0, 32'd32,   32'd2},
        '{2'd2, 24'd2, 24'd1,  1'b0, 32'd256,  32'd2},
        '{2'd3, 24'd1, 24'd1,  1'b0, 32'd2048, 32'd2},
        '{2'd0, 24'd9, 24'd0,  1'b1, 32'd10,   32'd0}
    };

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic measure(int n, output int lo, output int rises);
        logic prev;
        lo = 0; rises = 0;
        @(negedge clk);
        prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!pwm_out) lo++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    function automatic int div_of(logic [1:0] p);
        case (p)
            2'd0: return 1;
            2'd1: return 16;
            2'd2: return 256;
            default: return 2048;
        endcase
    endfunction

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lo, ri, hi, win;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 pwm_out", {31'd0, pwm_out}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rd(3'd0, d); check("R1 ctrl", d, 0);
        rd(3'd1, d); check("R1 period", d, 0);
        rd(3'd4, d); check("R1 flags", d, 0);

        // R2 R3 R4: vector table
        foreach (VECS[i]) begin
            wr(3'd0, 32'd0);
            wr(3'd1, {8'd0, VECS[i].per});
            wr(3'd2, {8'd0, VECS[i].low});
            wr(3'd0, {28'd0, VECS[i].psc, VECS[i].inv, 1'b1});
            win = div_of(VECS[i].psc) * (int'(VECS[i].per) + 1);
            repeat (2 * win) @(negedge clk);
            measure(2 * win, lo, ri);
            check($sformatf("R2/R3/R4 vec%0d low clocks", i), lo, 2 * VECS[i].exp_low);
            check($sformatf("R2 vec%0d rising edges", i), ri, VECS[i].exp_rise);
        end

        // R5: idle level follows polarity
        wr(3'd0, 32'd2);
        repeat (3) @(negedge clk);
        check("R5 idle inverted", {31'd0, pwm_out}, 1);
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        check("R5 idle normal", {31'd0, pwm_out}, 0);

        // R6: period write while running is ignored
        wr(3'd1, 32'd9);
        wr(3'd2, 32'd3);
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd5);
        rd(3'd1, d); check("R6 period readback", d, 9);
        repeat (20) @(negedge clk);
        measure(20, lo, ri);
        check("R6 low clocks", lo, 6);
        check("R6 rising edges", ri, 2);

        // R7: new width waits for the wrap
        begin
            logic prev;
            @(negedge clk);
            prev = pwm_out;
            forever begin
                @(negedge clk);
                if (pwm_out && !prev) break;
                prev = pwm_out;
            end
            wr_en = 1'b1; addr = 3'd2; wdata = 32'd6;
            hi = 1;
            forever begin
                @(negedge clk);
                wr_en = 1'b0;
                if (pwm_out) hi++; else break;
            end
            lo = 1;
            forever begin
                @(negedge clk);
                if (!pwm_out) lo++; else break;
            end
            check("R7 high phase kept old width", hi, 7);
            check("R7 next low phase uses new width", lo, 6);
        end
        wr(3'd0, 32'd0);

        // R8 R9 R10: flags, clearing, line
        wr(3'd3, 32'd7);
        wr(3'd2, 32'd3);
        wr(3'd0, 32'd1);
        repeat (25) @(negedge clk);
        rd(3'd4, d); check("R8 all flags set", d, 7);
        check("R10 irq high", {31'd0, irq}, 1);
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        wr(3'd4, 32'd1);
        rd(3'd4, d); check("R9 clear rise only", d, 6);
        wr(3'd3, 32'd0);
        @(negedge clk);
        check("R10 irq masked", {31'd0, irq}, 0);
        rd(3'd4, d); check("R10 flags kept when masked", d, 6);
        wr(3'd4, 32'd6);
        rd(3'd4, d); check("R9 cleared", d, 0);

        // R8: disabled sources stay clear
        wr(3'd0, 32'd1);
        repeat (25) @(negedge clk);
        rd(3'd4, d); check("R8 disabled flags", d, 0);
        check("R10 irq idle", {31'd0, irq}, 0);
        wr(3'd0, 32'd0);

        // R8: wrap flag alone when width 0
        wr(3'd3, 32'd7);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd3);
        wr(3'd0, 32'd1);
        repeat (10) @(negedge clk);
        wr(3'd4, 32'd7);
        repeat (20) @(negedge clk);
        rd(3'd4, d); check("R8 wrap only", d, 4);
        wr(3'd0, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule